// File: doc/BRIEF.md
# Infrared Serial Pulse Decoder

This block turns the short optical pulses seen on an infrared receive line back into a plain NRZ serial stream that a UART receiver can sample. It runs on a clock at sixteen times the baud rate. The receive line idles high, and each pulse pulls it low for only a fraction of a bit. The pulse may be 3/16 of a bit wide or a fixed short width.

The line is first brought into the clock domain through a short flop chain. Only the high-to-low transition of the synchronized line matters. Each such transition loads a bit-time counter. The serial output is held low while that counter is non-zero, so every pulse becomes one full space bit. A transition that arrives during a stretch reloads the counter, so back-to-back zeros merge into one unbroken low level.

A synchronous active-low reset clears the decoder. While the reset is held, it also blocks reception, and the output stays at the idle-high level.

Top module: `ir_pulse_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `rx_nrz` is high after that edge. Activity on `ir_rx` during reset produces no low level on `rx_nrz`, either during reset or after a release with `ir_rx` high.
- R2: A high-to-low change of `ir_rx` (low = pulse present, high = no light) makes `rx_nrz` go low after the second rising edge that follows the first edge sampling `ir_rx` low. That is the synchronizer depth (`SYNC_STAGES` = 2) plus one edge-detect cycle.
- R3: An isolated pulse holds `rx_nrz` low for exactly `BIT_TICKS` (16) clock cycles, after which `rx_nrz` returns high. This is never less than 3/4 of a bit time.
- R4: The stretched low length does not depend on the pulse width. A pulse of 1, 2, 3 or 5 cycles, and a low level held longer than a bit, each give the same 16-cycle low. The low-to-high change of `ir_rx` has no effect.
- R5: A new falling edge on `ir_rx` while `rx_nrz` is low reloads the stretch. `rx_nrz` then stays low without a gap until `BIT_TICKS` cycles after the later edge is loaded.
- R6: With no falling edge on `ir_rx` for more than `BIT_TICKS + SYNC_STAGES + 1` cycles, `rx_nrz` is high (mark/idle).
- R7: Asserting `rst_n` low during a stretch ends it: `rx_nrz` is high after the first edge that samples the reset. After the release it stays high while `ir_rx` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at 16 times the baud rate |
| rst_n | input | 1 | Synchronous active-low reset; also blocks reception while held low |
| ir_rx | input | 1 | Infrared receive line, idle high, low during a pulse |
| rx_nrz | output | 1 | Recovered serial data, idle high, toward the UART receive input |

## Verification
A bad count in the stretch counter shows at `rx_nrz` as a low run whose length is not 16, or as a low run that stops early when two pulses are close. This is visible within about twenty cycles of the falling input edge. A bad synchronizer or edge state shows as a shifted start of the low level: the low should begin exactly three samples after the stimulus. It can also show as a second or missing low run, for example on the rising edge of a long pulse or after a reset that happened during input activity. The bench measures the start and the length of every low run against values derived from pulse timing alone.

// File: rtl/irpd_pkg.sv
// Package: shared defaults and the line level encoding for the IR pulse decoder.
// Assumes: a serial line idles high (mark) and a space is driven low.
package irpd_pkg;
    localparam int unsigned DEF_BIT_TICKS   = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic {
        LINE_SPACE = 1'b0,
        LINE_MARK  = 1'b1
    } line_e;
endpackage

// File: rtl/irpd_sync.sv
// Module: irpd_sync
// Brings an asynchronous level into the clk domain through a chain of flops.
// Assumes: STAGES >= 1; the chain resets to RESET_VAL so that no edge appears at reset.
module irpd_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Purpose: first capture flop of the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RESET_VAL;
                else        stage_q[0] <= d_async;
            end
        end else begin : g_next
            // Purpose: later flop of the chain, settles the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= RESET_VAL;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/irpd_edge.sv
// Module: irpd_edge
// Flags one cycle when a synchronized level goes from high to low.
// Assumes: lvl is already in the clk domain; the history flop resets high,
// matching the idle level, so reset never creates an edge.
module irpd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    // Purpose: remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    // Purpose: high-to-low detection; the rising direction is deliberately ignored.
    always_comb begin
        fall = prev_q & ~lvl;
    end
endmodule

// File: rtl/irpd_stretch.sv
// Module: irpd_stretch
// Turns a one-cycle trigger into a space lasting BIT_TICKS cycles; a trigger
// during a running stretch reloads the count so adjacent spaces merge.
// Assumes: BIT_TICKS >= 1; trig is a single-cycle pulse.
module irpd_stretch #(
    parameter int unsigned BIT_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic space
);
    localparam int unsigned CNT_W = $clog2(BIT_TICKS + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BIT_TICKS);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: load on a trigger, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (trig)         cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Purpose: a non-zero count means the output is in a space.
    always_comb begin
        space = (cnt_q != '0);
    end
endmodule

// File: rtl/ir_pulse_decoder.sv
// Module: ir_pulse_decoder (top)
// Recovers NRZ serial data from an infrared receive line: every falling edge
// of the synchronized line produces one bit-time space on rx_nrz.
// Assumes: clk runs at 16x baud; every pulse lasts at least one clk period;
// rst_n is synchronous and active low and also blocks reception while low.
module ir_pulse_decoder
    import irpd_pkg::*;
#(
    parameter int unsigned BIT_TICKS   = DEF_BIT_TICKS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_rx,
    output logic rx_nrz
);
    logic ir_sync;
    logic ir_fall;
    logic in_space;
    line_e line_lvl;

    irpd_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ir_rx),
        .q_sync  (ir_sync)
    );

    irpd_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ir_sync),
        .fall  (ir_fall)
    );

    irpd_stretch #(
        .BIT_TICKS (BIT_TICKS)
    ) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (ir_fall),
        .space (in_space)
    );

    // Purpose: map the stretch state onto the serial line levels.
    always_comb begin
        line_lvl = in_space ? LINE_SPACE : LINE_MARK;
    end

    assign rx_nrz = line_lvl;
endmodule

// File: rtl/irpd_chk.sv
// Module: irpd_chk
// Port-level checker for ir_pulse_decoder, bound into every instance.
// Assumes: the same parameters as the decoder it is bound to.
module irpd_chk #(
    parameter int unsigned BIT_TICKS   = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ir_rx,
    input logic rx_nrz
);
    localparam int unsigned IDLE_LIMIT = BIT_TICKS + SYNC_STAGES + 1;

    logic [SYNC_STAGES:0] hist_q;
    int unsigned          low_run;
    int unsigned          hi_run;
    int unsigned          since_rst;

    // Purpose: input history, observed low runs, idle runs and time since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q    <= '1;
            low_run   <= 0;
            hi_run    <= 0;
            since_rst <= 0;
        end else begin
            hist_q    <= {hist_q[SYNC_STAGES-1:0], ir_rx};
            low_run   <= rx_nrz ? 0 : ((low_run < 1000) ? low_run + 1 : low_run);
            hi_run    <= !ir_rx ? 0 : ((hi_run < 1000) ? hi_run + 1 : hi_run);
            since_rst <= (since_rst < 1000) ? since_rst + 1 : since_rst;
        end
    end

    // R1: reset forces the idle level on the next edge
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> rx_nrz);

    // R2: a space only begins a fixed latency after the input was sampled low
    a_r2_fall_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_nrz) && since_rst > SYNC_STAGES + 1) |-> !hist_q[SYNC_STAGES]);

    // R3: a space that ends without reset lasted at least a full bit
    a_r3_full_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_nrz) && $past(rst_n)) |-> (low_run >= BIT_TICKS));

    // R6: a long quiet input means the line is at mark
    a_r6_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run >= IDLE_LIMIT) |-> rx_nrz);
endmodule

bind ir_pulse_decoder irpd_chk #(
    .BIT_TICKS   (BIT_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
) u_irpd_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ir_rx  (ir_rx),
    .rx_nrz (rx_nrz)
);

// File: tb/tb_ir_pulse_decoder.sv
module tb_ir_pulse_decoder;
    localparam int TICKS  = 16;
    localparam int WINDOW = 64;
    localparam int NVEC   = 10;

    // width of each pulse, start of second pulse (0 = none), expected low length
    typedef struct packed {
        int w;
        int g;
        int len;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1,  0, 16},   // R4 one-cycle pulse
        '{2,  0, 16},   // R4
        '{3,  0, 16},   // R3 nominal 3/16 pulse
        '{5,  0, 16},   // R4
        '{20, 0, 16},   // R4 low longer than a bit, rising edge ignored
        '{3, 16, 32},   // R5 consecutive zeros
        '{3,  8, 24},   // R5 retrigger mid-stretch
        '{3,  4, 20},   // R5 early retrigger
        '{1,  2, 18},   // R5 narrow pulses close together
        '{8, 10, 26}    // R5 wide pulses
    };

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic ir_rx = 1'b1;
    logic rx_nrz;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    ir_pulse_decoder #(.BIT_TICKS(TICKS), .SYNC_STAGES(2)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir_rx  (ir_rx),
        .rx_nrz (rx_nrz)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // one table entry: sample output then drive input at each falling clock edge
    task automatic run_vec(input int idx, input int w, input int g, input int len);
        int first = -1;
        int cnt   = 0;
        bit split = 1'b0;
        bit ended = 1'b0;
        for (int t = 0; t < WINDOW; t++) begin
            @(negedge clk);
            if (!rx_nrz) begin
                if (first < 0) first = t;
                else if (ended) split = 1'b1;
                cnt++;
            end else if (first >= 0) begin
                ended = 1'b1;
            end
            ir_rx = !((t < w) || (g > 0 && t >= g && t < g + w));
        end
        check(first == 3, (g > 0) ? "R5" : "R2", $sformatf("vec%0d low start", idx), first, 3);
        check(cnt == len && !split, (g > 0) ? "R5" : ((w == 3) ? "R3" : "R4"),
              $sformatf("vec%0d low length", idx), split ? -1 : cnt, len);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        int lows;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rx_nrz == 1'b1, "R1", "idle in reset", rx_nrz, 1);

        // R1: input activity during reset is blocked
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!rx_nrz) lows++;
            ir_rx = i[1];
        end
        ir_rx = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!rx_nrz) lows++;
        end
        check(lows == 0, "R1", "low cycles from activity in reset", lows, 0);

        // table of pulse patterns
        for (int v = 0; v < NVEC; v++) begin
            run_vec(v, VECS[v].w, VECS[v].g, VECS[v].len);
        end

        // R6: quiet line stays at mark
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!rx_nrz) lows++;
        end
        check(lows == 0, "R6", "low cycles on idle line", lows, 0);

        // R7: reset during a stretch
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            ir_rx = !(t < 3);
        end
        @(negedge clk);
        check(rx_nrz == 1'b0, "R7", "stretch running before reset", rx_nrz, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(rx_nrz == 1'b1, "R7", "stretch ended by reset", rx_nrz, 1);
        @(negedge clk);
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!rx_nrz) lows++;
        end
        check(lows == 0, "R7", "low cycles after release", lows, 0);

        // R2: a pulse right after that release is decoded normally
        run_vec(NVEC, 3, 0, 16);

        done = 1'b1;
        report();
        $finish;
    end
endmodule